// File: doc/BRIEF.md
# I2C Multi-Segment Transaction Sequencer

This block turns one multi-segment I2C command into a sequence of operations for a separate bit-level bus engine. A command gives a bus speed in kHz and a segment count. Each segment is then taken from a descriptor stream and carries a 7-bit target address, a direction and a byte length. Write payload bytes are pulled from an input byte stream as they are needed. Read bytes are pushed out on an output byte stream as the engine returns them.

The sequencer works out the bit period and its quarter, and hands that quarter to the engine with every operation. It builds the address byte and issues START, byte-write, byte-read and STOP operations one at a time. Every segment except the last leaves the bus held, so the next segment opens with a repeated START. The first failed operation ends the command. A STOP is still sent after a failure, and completion is reported as a one-cycle pulse with a success flag.

The engine handshake works as follows. `eng_req` is held with a stable operation until the engine answers with a one-cycle `eng_done` and a status on `eng_ok`. A byte write reports `eng_ok` low when the target answers NACK.

Top module: `i2c_seq`

## Requirements
- R1: On command acceptance, the bit period in microseconds is set to 1000 divided by the speed, using integer division. A speed of 0 uses `DEF_KHZ` in its place. A result below `MIN_PERIOD` is raised to `MIN_PERIOD`. `eng_qdelay` is that period shifted right by 2, and it stays in force for the whole command.
- R2: The address byte sent for a segment is the 7-bit address in bits 7:1, with bit 0 equal to 1 for a read and 0 for a write.
- R3: Each segment begins with a START operation (`eng_op` = 0). The next operation is a byte write (`eng_op` = 2) of the address byte.
- R4: A write segment sends its payload bytes in stream order with byte writes. A byte write that reports failure (NACK) fails the segment.
- R5: A read segment issues one byte read (`eng_op` = 3) per byte. `eng_more` is 1 (ACK) for every byte except the last, where it is 0 (NACK). Each successful read appears once on `rd_valid`/`rd_data`, in order.
- R6: A segment that is not the last one issues no STOP. The next descriptor is fetched only after the current segment completes, and that segment opens with a START.
- R7: A STOP (`eng_op` = 1) follows the last segment. A STOP is also issued right after any failed START, address or data operation.
- R8: A STOP that reports failure makes the command fail.
- R9: After the first failure, no further descriptor, payload byte or non-STOP operation is consumed, and `success` is 0.
- R10: A zero-length segment issues only START, the address byte and, when it is last, the STOP.
- R11: `done` is high for exactly one cycle per accepted command. A command with 0 segments completes at once with `success` = 1 and no engine operations.
- R12: While `eng_req` is high and `eng_done` has not been seen, `eng_op` and `eng_wdata` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command accepted when valid |
| cmd_speed | input | SPD_W | Bus speed in kHz, 0 selects default |
| cmd_nseg | input | SEG_W | Number of segments in the command |
| seg_valid | input | 1 | Segment descriptor offered |
| seg_ready | output | 1 | Descriptor taken when valid |
| seg_addr | input | 7 | 7-bit target address |
| seg_rd | input | 1 | 1 = read segment, 0 = write segment |
| seg_len | input | LEN_W | Byte count of the segment |
| wr_valid | input | 1 | Write payload byte offered |
| wr_ready | output | 1 | Write payload byte taken when valid |
| wr_data | input | 8 | Write payload byte |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| eng_req | output | 1 | Engine operation request |
| eng_op | output | 2 | 0 START, 1 STOP, 2 byte write, 3 byte read |
| eng_wdata | output | 8 | Byte to write |
| eng_more | output | 1 | For reads: 1 send ACK, 0 send NACK |
| eng_qdelay | output | DLY_W | Quarter bit period in microseconds |
| eng_done | input | 1 | Engine operation finished |
| eng_ok | input | 1 | Operation succeeded (ACK seen for writes) |
| eng_rdata | input | 8 | Byte returned by a read |
| done | output | 1 | Command complete pulse |
| success | output | 1 | Command result, valid with done |

## Verification
The bench builds the block with `SEG_W` = 2 and `LEN_W` = 4, so commands of up to three segments and lengths up to 15 can be covered. It sets `DEF_KHZ` = 50, which gives a quarter period of 5 and keeps the speed-0 case apart from the 12 µs floor. These widths make chains with two repeated starts cheap to set up. The engine model can inject a failure at any chosen operation, which covers the START, address, write, read and STOP failure paths within a few hundred cycles.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } eng_op_t;

  // Bit period in microseconds from a speed in kHz (R1).
  function automatic logic [31:0] bit_period_us(input logic [31:0] khz,
                                                input logic [31:0] def_khz,
                                                input logic [31:0] scale,
                                                input logic [31:0] min_p);
    logic [31:0] s;
    logic [31:0] p;
    s = (khz == 32'd0) ? def_khz : khz;
    p = scale / s;
    if (p < min_p) p = min_p;
    return p;
  endfunction

  // Address byte: address in bits 7:1, direction in bit 0 (R2).
  function automatic logic [7:0] addr_byte(input logic [6:0] a7, input logic rd);
    return {a7, rd};
  endfunction

endpackage

// File: rtl/i2c_seq_rate.sv
module i2c_seq_rate #(
  parameter int SPD_W      = 16,
  parameter int DLY_W      = 16,
  parameter int DEF_KHZ    = 50,
  parameter int MIN_PERIOD = 12,
  parameter int SCALE      = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SPD_W-1:0] speed,
  output logic [DLY_W-1:0] qdelay
);
  localparam logic [DLY_W-1:0] RST_Q = DLY_W'(MIN_PERIOD >> 2);

  logic [31:0] period;
  assign period = i2c_seq_pkg::bit_period_us(32'(speed), 32'(DEF_KHZ),
                                             32'(SCALE), 32'(MIN_PERIOD));

  always_ff @(posedge clk) begin
    if (!rst_n)    qdelay <= RST_Q;
    else if (load) qdelay <= DLY_W'(period >> 2);
  end
endmodule

// File: rtl/i2c_seq_ctrl.sv
module i2c_seq_ctrl #(
  parameter int SEG_W = 3,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [SEG_W-1:0] cmd_nseg,
  output logic             cmd_take,
  input  logic             seg_valid,
  output logic             seg_ready,
  input  logic [6:0]       seg_addr,
  input  logic             seg_rd,
  input  logic [LEN_W-1:0] seg_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             eng_req,
  output logic [1:0]       eng_op,
  output logic [7:0]       eng_wdata,
  output logic             eng_more,
  input  logic             eng_done,
  input  logic             eng_ok,
  input  logic [7:0]       eng_rdata,
  output logic             eng_fire,
  output logic             op_fail,
  output logic             done,
  output logic             success
);
  import i2c_seq_pkg::*;

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_START, S_ADDR, S_WGET, S_WR, S_RD, S_SEGEND, S_STOP, S_DONE
  } st_t;

  st_t              st;
  logic [SEG_W-1:0] segs_left;
  logic [LEN_W-1:0] len_left;
  logic [6:0]       cur_addr;
  logic             cur_rd;
  logic [7:0]       wbyte;
  logic             failed;
  logic             last_seg;
  logic             last_byte;

  assign cmd_ready = (st == S_IDLE);
  assign cmd_take  = cmd_ready && cmd_valid;
  assign seg_ready = (st == S_FETCH);
  assign wr_ready  = (st == S_WGET);
  assign eng_req   = (st == S_START) || (st == S_ADDR) || (st == S_WR) ||
                     (st == S_RD) || (st == S_STOP);
  assign eng_fire  = eng_req && eng_done;
  assign op_fail   = eng_fire && !eng_ok;
  assign last_seg  = (segs_left == SEG_W'(1));
  assign last_byte = (len_left == LEN_W'(1));
  assign eng_more  = !last_byte;
  assign eng_wdata = (st == S_ADDR) ? addr_byte(cur_addr, cur_rd) : wbyte;
  assign done      = (st == S_DONE);
  assign success   = !failed;

  always_comb begin
    case (st)
      S_START: eng_op = OP_START;
      S_STOP:  eng_op = OP_STOP;
      S_RD:    eng_op = OP_READ;
      default: eng_op = OP_WRITE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      segs_left <= '0;
      len_left  <= '0;
      cur_addr  <= '0;
      cur_rd    <= 1'b0;
      wbyte     <= '0;
      failed    <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (cmd_take) begin
          segs_left <= cmd_nseg;
          failed    <= 1'b0;
          st        <= (cmd_nseg == '0) ? S_DONE : S_FETCH;
        end
        S_FETCH: if (seg_valid) begin
          cur_addr <= seg_addr;
          cur_rd   <= seg_rd;
          len_left <= seg_len;
          st       <= S_START;
        end
        S_START: if (eng_fire) begin
          if (eng_ok) st <= S_ADDR;
          else begin failed <= 1'b1; st <= S_STOP; end
        end
        S_ADDR: if (eng_fire) begin
          if (!eng_ok)               begin failed <= 1'b1; st <= S_STOP; end
          else if (len_left == '0)   st <= S_SEGEND;
          else                       st <= cur_rd ? S_RD : S_WGET;
        end
        S_WGET: if (wr_valid) begin
          wbyte <= wr_data;
          st    <= S_WR;
        end
        S_WR: if (eng_fire) begin
          if (!eng_ok) begin failed <= 1'b1; st <= S_STOP; end
          else begin
            len_left <= len_left - LEN_W'(1);
            st       <= last_byte ? S_SEGEND : S_WGET;
          end
        end
        S_RD: if (eng_fire) begin
          if (!eng_ok) begin failed <= 1'b1; st <= S_STOP; end
          else begin
            rd_valid <= 1'b1;
            rd_data  <= eng_rdata;
            len_left <= len_left - LEN_W'(1);
            st       <= last_byte ? S_SEGEND : S_RD;
          end
        end
        S_SEGEND: begin
          if (last_seg) st <= S_STOP;
          else begin
            segs_left <= segs_left - SEG_W'(1);
            st        <= S_FETCH;
          end
        end
        S_STOP: if (eng_fire) begin
          if (!eng_ok) failed <= 1'b1;
          st <= S_DONE;
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_seq.sv
module i2c_seq #(
  parameter int SEG_W      = 3,
  parameter int LEN_W      = 8,
  parameter int SPD_W      = 16,
  parameter int DLY_W      = 16,
  parameter int DEF_KHZ    = 50,
  parameter int MIN_PERIOD = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [SPD_W-1:0] cmd_speed,
  input  logic [SEG_W-1:0] cmd_nseg,
  input  logic             seg_valid,
  output logic             seg_ready,
  input  logic [6:0]       seg_addr,
  input  logic             seg_rd,
  input  logic [LEN_W-1:0] seg_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             eng_req,
  output logic [1:0]       eng_op,
  output logic [7:0]       eng_wdata,
  output logic             eng_more,
  output logic [DLY_W-1:0] eng_qdelay,
  input  logic             eng_done,
  input  logic             eng_ok,
  input  logic [7:0]       eng_rdata,
  output logic             done,
  output logic             success
);
  logic cmd_take;
  logic eng_fire;
  logic op_fail;

  i2c_seq_rate #(
    .SPD_W(SPD_W), .DLY_W(DLY_W), .DEF_KHZ(DEF_KHZ),
    .MIN_PERIOD(MIN_PERIOD), .SCALE(1000)
  ) u_rate (
    .clk(clk), .rst_n(rst_n), .load(cmd_take), .speed(cmd_speed), .qdelay(eng_qdelay)
  );

  i2c_seq_ctrl #(.SEG_W(SEG_W), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_nseg(cmd_nseg), .cmd_take(cmd_take),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_rd(seg_rd), .seg_len(seg_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata), .eng_more(eng_more),
    .eng_done(eng_done), .eng_ok(eng_ok), .eng_rdata(eng_rdata),
    .eng_fire(eng_fire), .op_fail(op_fail),
    .done(done), .success(success)
  );
endmodule

// File: rtl/i2c_seq_checker.sv
module i2c_seq_checker #(
  parameter int DLY_W      = 16,
  parameter int MIN_PERIOD = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_take,
  input logic             seg_ready,
  input logic             wr_ready,
  input logic             rd_valid,
  input logic             eng_req,
  input logic [1:0]       eng_op,
  input logic [7:0]       eng_wdata,
  input logic [DLY_W-1:0] eng_qdelay,
  input logic             eng_done,
  input logic             eng_ok,
  input logic             op_fail,
  input logic             done,
  input logic             success
);
  localparam logic [DLY_W-1:0] QMIN = DLY_W'(MIN_PERIOD >> 2);

  logic saw_fail;
  always_ff @(posedge clk) begin
    if (!rst_n || cmd_take) saw_fail <= 1'b0;
    else if (op_fail)       saw_fail <= 1'b1;
  end

  p_op_held_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_done) |=> (eng_req && $stable(eng_op) && $stable(eng_wdata)));

  p_qdelay_floor_r1: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> (eng_qdelay >= QMIN));

  p_addr_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && eng_done && eng_ok && eng_op == 2'd0) |=> (eng_req && eng_op == 2'd2));

  p_forced_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_fail && eng_op != 2'd1) |=> (eng_req && eng_op == 2'd1));

  p_rd_from_ok_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(eng_req && eng_done && eng_ok && eng_op == 2'd3));

  p_abort_no_fetch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    saw_fail |-> (!seg_ready && !wr_ready));

  p_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (success == !saw_fail));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind i2c_seq i2c_seq_checker #(.DLY_W(DLY_W), .MIN_PERIOD(MIN_PERIOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_take(cmd_take), .seg_ready(seg_ready),
  .wr_ready(wr_ready), .rd_valid(rd_valid), .eng_req(eng_req), .eng_op(eng_op),
  .eng_wdata(eng_wdata), .eng_qdelay(eng_qdelay), .eng_done(eng_done),
  .eng_ok(eng_ok), .op_fail(op_fail), .done(done), .success(success)
);

// File: tb/i2c_seq_bench.sv
module i2c_seq_bench;
  localparam int SEG_W = 2;
  localparam int LEN_W = 4;
  localparam int DLY_W = 16;
  localparam int MAXOP = 48;
  localparam int NVEC  = 10;

  function automatic logic [11:0] sg(input logic [6:0] a, input logic r, input logic [3:0] l);
    return {a, r, l};
  endfunction

  typedef struct packed {
    logic [15:0]      spd;
    logic [1:0]       nseg;
    logic [2:0][11:0] seg;
    logic [7:0]       fail_at;
    logic [15:0]      q;
    logic             ok;
  } vec_t;

  localparam vec_t VEC [NVEC] = '{
    '{16'd100, 2'd1, {12'h0, 12'h0, sg(7'h50, 1'b0, 4'd2)}, 8'hFF, 16'd3, 1'b1},
    '{16'd0,   2'd2, {12'h0, sg(7'h50, 1'b1, 4'd3), sg(7'h50, 1'b0, 4'd1)}, 8'hFF, 16'd5, 1'b1},
    '{16'd10,  2'd1, {12'h0, 12'h0, sg(7'h3C, 1'b1, 4'd1)}, 8'hFF, 16'd25, 1'b1},
    '{16'd1,   2'd2, {12'h0, sg(7'h12, 1'b1, 4'd0), sg(7'h12, 1'b0, 4'd0)}, 8'hFF, 16'd250, 1'b1},
    '{16'd60,  2'd2, {12'h0, sg(7'h21, 1'b1, 4'd2), sg(7'h20, 1'b0, 4'd3)}, 8'd3, 16'd4, 1'b0},
    '{16'd400, 2'd2, {12'h0, sg(7'h05, 1'b0, 4'd1), sg(7'h04, 1'b0, 4'd1)}, 8'd0, 16'd3, 1'b0},
    '{16'd100, 2'd1, {12'h0, 12'h0, sg(7'h7F, 1'b0, 4'd1)}, 8'd3, 16'd3, 1'b0},
    '{16'd83,  2'd3, {sg(7'h33, 1'b0, 4'd1), sg(7'h22, 1'b1, 4'd2), sg(7'h11, 1'b0, 4'd1)}, 8'd4, 16'd3, 1'b0},
    '{16'd20,  2'd1, {12'h0, 12'h0, sg(7'h40, 1'b1, 4'd3)}, 8'd3, 16'd12, 1'b0},
    '{16'd250, 2'd3, {sg(7'h03, 1'b1, 4'd1), sg(7'h02, 1'b0, 4'd2), sg(7'h01, 1'b1, 4'd2)}, 8'hFF, 16'd3, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             cmd_valid = 1'b0;
  logic             cmd_ready;
  logic [15:0]      cmd_speed = '0;
  logic [SEG_W-1:0] cmd_nseg = '0;
  logic             seg_valid;
  logic             seg_ready;
  logic [6:0]       seg_addr;
  logic             seg_rd;
  logic [LEN_W-1:0] seg_len;
  logic             wr_valid;
  logic             wr_ready;
  logic [7:0]       wr_data;
  logic             rd_valid;
  logic [7:0]       rd_data;
  logic             eng_req;
  logic [1:0]       eng_op;
  logic [7:0]       eng_wdata;
  logic             eng_more;
  logic [DLY_W-1:0] eng_qdelay;
  logic             eng_done = 1'b0;
  logic             eng_ok = 1'b0;
  logic [7:0]       eng_rdata = '0;
  logic             done;
  logic             success;

  i2c_seq #(.SEG_W(SEG_W), .LEN_W(LEN_W), .SPD_W(16), .DLY_W(DLY_W),
            .DEF_KHZ(50), .MIN_PERIOD(12)) u_i2c_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_speed(cmd_speed), .cmd_nseg(cmd_nseg),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_rd(seg_rd), .seg_len(seg_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .eng_req(eng_req), .eng_op(eng_op), .eng_wdata(eng_wdata), .eng_more(eng_more),
    .eng_qdelay(eng_qdelay), .eng_done(eng_done), .eng_ok(eng_ok), .eng_rdata(eng_rdata),
    .done(done), .success(success)
  );

  int errors = 0;
  int checks = 0;

  task automatic check(input bit cond, input string what, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // Stimulus streams and engine model state
  logic [2:0][11:0] cur_seg = '0;
  int  cur_nseg = 0;
  int  d_idx = 0, w_idx = 0;
  bit  d_pend = 0, w_pend = 0;
  int  fail_at = 255;
  int  n_ops = 0, n_rd = 0, lat = 0;
  logic [1:0] req_op0;
  logic [7:0] req_dat0;
  logic [1:0]  t_op   [MAXOP];
  logic [7:0]  t_dat  [MAXOP];
  logic        t_more [MAXOP];
  logic [15:0] t_q    [MAXOP];
  logic [7:0]  r_dat  [MAXOP];
  int  n_rx = 0;

  assign seg_valid = (d_idx < cur_nseg);
  assign seg_addr  = cur_seg[d_idx[1:0]][11:5];
  assign seg_rd    = cur_seg[d_idx[1:0]][4];
  assign seg_len   = cur_seg[d_idx[1:0]][3:0];
  assign wr_valid  = 1'b1;
  assign wr_data   = 8'h30 + 8'(w_idx);

  always @(negedge clk) begin
    if (d_pend) d_idx++;
    if (w_pend) w_idx++;
    d_pend = seg_valid && seg_ready;
    w_pend = wr_valid && wr_ready;
    if (rd_valid && n_rx < MAXOP) begin r_dat[n_rx] = rd_data; n_rx++; end
    if (eng_done) eng_done = 1'b0;
    else if (eng_req) begin
      if (lat == 0) begin req_op0 = eng_op; req_dat0 = eng_wdata; end
      lat++;
      if (lat == 2) begin
        check(eng_op == req_op0 && eng_wdata == req_dat0, "R12 op held until done",
              int'(eng_op), int'(req_op0));
        if (n_ops < MAXOP) begin
          t_op[n_ops] = eng_op; t_dat[n_ops] = eng_wdata;
          t_more[n_ops] = eng_more; t_q[n_ops] = eng_qdelay;
        end
        eng_ok = (n_ops != fail_at);
        eng_rdata = 8'hC0 + 8'(n_rd);
        if (eng_op == 2'd3) n_rd++;
        n_ops++;
        eng_done = 1'b1;
        lat = 0;
      end
    end
  end

  // Expected trace from the requirements
  logic [1:0] e_op   [MAXOP];
  logic [7:0] e_dat  [MAXOP];
  logic       e_more [MAXOP];
  int e_n, e_segs, e_rdok;

  task automatic build_exp(input vec_t v);
    int n = 0, wc = 0, f;
    for (int s = 0; s < int'(v.nseg); s++) begin
      logic [6:0] a = v.seg[s][11:5];
      logic r = v.seg[s][4];
      int l = int'(v.seg[s][3:0]);
      e_op[n] = 2'd0; e_dat[n] = 8'h00; e_more[n] = 1'b0; n++;
      e_op[n] = 2'd2; e_dat[n] = {a, r}; e_more[n] = 1'b0; n++;
      for (int b = 0; b < l; b++) begin
        if (r) begin e_op[n] = 2'd3; e_dat[n] = 8'h00; e_more[n] = (b != l - 1); end
        else begin e_op[n] = 2'd2; e_dat[n] = 8'h30 + 8'(wc); e_more[n] = 1'b0; wc++; end
        n++;
      end
    end
    if (v.nseg != 0) begin e_op[n] = 2'd1; e_dat[n] = 8'h00; e_more[n] = 1'b0; n++; end
    f = int'(v.fail_at);
    if (f < n) begin
      if (e_op[f] != 2'd1) begin e_op[f+1] = 2'd1; n = f + 2; end
      else n = f + 1;
    end
    e_n = n; e_segs = 0; e_rdok = 0;
    for (int i = 0; i < n; i++) begin
      if (e_op[i] == 2'd0) e_segs++;
      if (e_op[i] == 2'd3 && i != f) e_rdok++;
    end
  endtask

  task automatic run_cmd(input vec_t v, input int idx);
    int wd = 0;
    @(negedge clk);
    cur_seg = v.seg; cur_nseg = int'(v.nseg);
    d_idx = 0; w_idx = 0; d_pend = 0; w_pend = 0;
    n_ops = 0; n_rd = 0; n_rx = 0; lat = 0;
    fail_at = int'(v.fail_at);
    cmd_speed = v.spd; cmd_nseg = SEG_W'(v.nseg); cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done && wd < 2000) begin @(negedge clk); wd++; end
    check(done == 1'b1, $sformatf("R11 vec%0d done seen", idx), int'(done), 1);
    check(success == v.ok, $sformatf("R8 R9 vec%0d success", idx), int'(success), int'(v.ok));
    build_exp(v);
    check(n_ops == e_n, $sformatf("R3 R7 R10 vec%0d op count", idx), n_ops, e_n);
    for (int i = 0; i < e_n && i < n_ops; i++) begin
      if (e_op[i] == 2'd2 && i > 0 && e_op[i-1] == 2'd0)
        check(t_op[i] == 2'd2 && t_dat[i] == e_dat[i],
              $sformatf("R2 R3 vec%0d op%0d address", idx, i), int'(t_dat[i]), int'(e_dat[i]));
      else if (e_op[i] == 2'd2)
        check(t_op[i] == 2'd2 && t_dat[i] == e_dat[i],
              $sformatf("R4 vec%0d op%0d write", idx, i), int'(t_dat[i]), int'(e_dat[i]));
      else if (e_op[i] == 2'd3)
        check(t_op[i] == 2'd3 && t_more[i] == e_more[i],
              $sformatf("R5 vec%0d op%0d read ack", idx, i), int'(t_more[i]), int'(e_more[i]));
      else if (e_op[i] == 2'd0)
        check(t_op[i] == 2'd0, $sformatf("R3 R6 vec%0d op%0d start", idx, i), int'(t_op[i]), 0);
      else
        check(t_op[i] == 2'd1, $sformatf("R7 vec%0d op%0d stop", idx, i), int'(t_op[i]), 1);
    end
    if (n_ops > 0)
      check(t_q[0] == v.q && t_q[n_ops-1] == v.q, $sformatf("R1 vec%0d quarter period", idx),
            int'(t_q[0]), int'(v.q));
    check(d_idx == e_segs, $sformatf("R6 R9 vec%0d descriptors taken", idx), d_idx, e_segs);
    check(n_rx == e_rdok, $sformatf("R5 vec%0d read bytes out", idx), n_rx, e_rdok);
    for (int i = 0; i < n_rx && i < e_rdok; i++)
      check(r_dat[i] == 8'hC0 + 8'(i), $sformatf("R5 vec%0d read byte %0d", idx, i),
            int'(r_dat[i]), 'hC0 + i);
    @(negedge clk);
    check(done == 1'b0, $sformatf("R11 vec%0d done one cycle", idx), int'(done), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    vec_t zv;
    repeat (3) @(negedge clk);
    check(cmd_ready && !done && !eng_req && !seg_ready && !wr_ready && !rd_valid,
          "R11 reset state idle", int'({cmd_ready, done, eng_req, seg_ready, wr_ready, rd_valid}), 32);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1 && eng_req == 1'b0, "R11 idle after reset", int'(cmd_ready), 1);

    for (int k = 0; k < NVEC; k++) run_cmd(VEC[k], k);

    // Zero-segment command: immediate success, no engine traffic
    zv = '{16'd100, 2'd0, 36'h0, 8'hFF, 16'd3, 1'b1};
    run_cmd(zv, 99);
    check(n_ops == 0, "R11 zero segments issue nothing", n_ops, 0);

    // Zero-length segment alone: START, address byte, STOP
    zv = '{16'd50, 2'd1, {12'h0, 12'h0, sg(7'h2A, 1'b1, 4'd0)}, 8'hFF, 16'd5, 1'b1};
    run_cmd(zv, 100);
    check(n_ops == 3 && n_rx == 0, "R10 zero-length read segment", n_ops, 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule